// File: doc/BRIEF.md
# Two-Deep Buffered Input Capture Channel

This block is a single input-capture channel that snapshots a free-running counter when a selected edge arrives on an external pin. The pin passes through a flop synchronizer. An edge detector then compares the synchronized level with its previous value, and the comparison is qualified by a programmable polarity: off, rising, falling or both. Timestamps go into a pair of registers. The newest value sits in the capture register, and the previous one moves into the holding register. An interrupt flag is raised each time the pair holds two fresh timestamps.

The channel keeps a full or empty state for each register. Software reads arrive as one-cycle strobes, and each strobe empties the register it names. In no-overwrite mode, edges cannot disturb a full pair until software has read both registers. Such an edge is not lost: it is remembered, and it raises the flag once both registers are empty. This holds whatever the order of the two reads and the flag-clear write. The flag is cleared by a write strobe carrying a 1 in the flag bit. A flag-set event in the same cycle overrides the clear.

Top module: `icap_buf_chan`

## Requirements
- R1: A mode write with a nonzero value marks both registers empty and restarts the first-edge sequence. The first-edge state is lost even when the channel was already running.
- R2: The first valid edge after such a write loads the counter into the capture register, marks it full and leaves the flag unchanged.
- R3: Each later valid edge moves the capture value into the holding register and loads the counter into the capture register. It marks both registers full and sets the flag in the same clock.
- R4: Mode encoding: 2'b01 selects rising edges, 2'b10 falling edges and 2'b11 both. The pin passes SYNC_STAGES flops plus one edge flop, so a capture appears SYNC_STAGES+1 clocks after the pin changes.
- R5: Mode 2'b00 disables the channel. Edges of either polarity leave both registers and the flag untouched.
- R6: With no-overwrite on and the holding register full, a valid edge changes neither register.
- R7: A capture read strobe empties the capture register, and a holding read strobe empties the holding register. The full indicators drop one clock later.
- R8: A valid edge blocked under R6 is remembered. It sets the flag one clock after both registers become empty, whether the flag was cleared before, between or together with the reads.
- R9: A flag write with data 1 clears the flag, and a flag write with data 0 has no effect. A flag-set event in the same clock as a clear leaves the flag set.
- R10: With no-overwrite off, every valid edge after the first shifts and sets the flag, even when neither register has been read.
- R11: With no-overwrite on, a valid edge that finds the capture register empty loads it without shifting and without setting the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Free-running counter value |
| pin_i | input | 1 | Asynchronous capture pin |
| mode_wr_i | input | 1 | Strobe: load mode_i into the edge-select register |
| mode_i | input | 2 | Edge select: 00 off, 01 rising, 10 falling, 11 both |
| nov_i | input | 1 | No-overwrite enable |
| rd_cap_i | input | 1 | Strobe: capture register read |
| rd_hold_i | input | 1 | Strobe: holding register read |
| flag_wr_i | input | 1 | Strobe: write to the flag bit |
| flag_wdata_i | input | 1 | Data written to the flag bit (1 clears) |
| cap_o | output | CNT_W | Capture register |
| hold_o | output | CNT_W | Holding register |
| cap_full_o | output | 1 | Capture register holds an unread value |
| hold_full_o | output | 1 | Holding register holds an unread value |
| flag_o | output | 1 | Capture interrupt flag |

## Verification
The bench builds the channel with CNT_W = 16 and SYNC_STAGES = 3. The deeper synchronizer exercises the generated stage chain beyond its minimum length and shifts every capture to four clocks after the pin change. Distinct 16-bit timestamps make it clear which edge filled which register. The width also allows a flag clear to be placed on exactly the clock of a shift, and a blocked edge to be placed between the two reads in both orders.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        ICAP_OFF  = 2'b00,
        ICAP_RISE = 2'b01,
        ICAP_FALL = 2'b10,
        ICAP_ANY  = 2'b11
    } icap_mode_e;

endpackage

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_i,
    output logic       hit_o,
    output logic       arm_o,
    output icap_mode_e mode_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] sync;
        logic          prev;
        icap_mode_e    mode;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     level, rise, fall;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[LAST];
        if (mode_wr_i) begin
            st_d.mode = icap_mode_e'(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: '0, prev: 1'b0, mode: ICAP_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sync[LAST];
    assign rise  = level & ~st_q.prev;
    assign fall  = ~level & st_q.prev;

    always_comb begin
        unique case (st_q.mode)
            ICAP_RISE: hit_o = rise;
            ICAP_FALL: hit_o = fall;
            ICAP_ANY:  hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

    assign arm_o  = mode_wr_i && (mode_i != 2'b00);
    assign mode_o = st_q.mode;

    // R5: a disabled channel reports no edge
    a_r5_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == ICAP_OFF) |-> !hit_o);

    // R4: a rising edge is never reported in falling-only mode
    a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == ICAP_FALL && rise) |-> !hit_o);

endmodule

// File: rtl/icap_store.sv
module icap_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             hit_i,
    input  logic             arm_i,
    input  logic             nov_i,
    input  logic             rd_cap_i,
    input  logic             rd_hold_i,
    output logic [CNT_W-1:0] cap_o,
    output logic [CNT_W-1:0] hold_o,
    output logic             cap_full_o,
    output logic             hold_full_o,
    output logic             set_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] hold;
        logic             cap_full;
        logic             hold_full;
        logic             primed;
        logic             missed;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      blocked, do_shift;

    assign blocked  = nov_i && st_q.hold_full;
    assign do_shift = st_q.primed && (!nov_i || st_q.cap_full);

    always_comb begin
        st_d  = st_q;
        set_o = 1'b0;
        if (rd_cap_i)  st_d.cap_full  = 1'b0;
        if (rd_hold_i) st_d.hold_full = 1'b0;
        if (arm_i) begin
            st_d.cap_full  = 1'b0;
            st_d.hold_full = 1'b0;
            st_d.primed    = 1'b0;
            st_d.missed    = 1'b0;
        end else begin
            if (hit_i) begin
                if (blocked) begin
                    st_d.missed = 1'b1;
                end else if (do_shift) begin
                    st_d.hold      = st_q.cap;
                    st_d.cap       = count_i;
                    st_d.cap_full  = 1'b1;
                    st_d.hold_full = 1'b1;
                    set_o          = 1'b1;
                end else begin
                    st_d.cap      = count_i;
                    st_d.cap_full = 1'b1;
                    st_d.primed   = 1'b1;
                end
            end
            if (st_q.missed && !st_q.cap_full && !st_q.hold_full) begin
                st_d.missed = 1'b0;
                set_o       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o       = st_q.cap;
    assign hold_o      = st_q.hold;
    assign cap_full_o  = st_q.cap_full;
    assign hold_full_o = st_q.hold_full;

    // R1: arming leaves both registers empty
    a_r1_arm_empties: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!st_q.cap_full && !st_q.hold_full));

    // R6: a full holding register is protected under no-overwrite
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (nov_i && st_q.hold_full && hit_i) |=> ($stable(st_q.cap) && $stable(st_q.hold)));

    // R7: a capture read without a competing edge empties the register
    a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap_i && !hit_i) |=> !st_q.cap_full);

    // R8: a remembered edge is released once both registers are empty
    a_r8_missed_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.missed && !st_q.cap_full && !st_q.hold_full) |=> !st_q.missed);

endmodule

// File: rtl/icap_flag.sv
module icap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     clr;

    assign clr = wr_i && wdata_i;

    always_comb begin
        st_d = st_q;
        if (clr)   st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R9: a set event beats a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr) |=> flag_o);

    // R9: a clear without a set drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_i) |=> !flag_o);

    // R9: a write of zero leaves the flag alone
    a_r9_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/icap_buf_chan.sv
module icap_buf_chan
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             pin_i,
    input  logic             mode_wr_i,
    input  logic [1:0]       mode_i,
    input  logic             nov_i,
    input  logic             rd_cap_i,
    input  logic             rd_hold_i,
    input  logic             flag_wr_i,
    input  logic             flag_wdata_i,
    output logic [CNT_W-1:0] cap_o,
    output logic [CNT_W-1:0] hold_o,
    output logic             cap_full_o,
    output logic             hold_full_o,
    output logic             flag_o
);

    logic       hit, arm, set_evt;
    icap_mode_e mode_q;

    icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .mode_wr_i (mode_wr_i),
        .mode_i    (mode_i),
        .hit_o     (hit),
        .arm_o     (arm),
        .mode_o    (mode_q)
    );

    icap_store #(.CNT_W(CNT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_i     (count_i),
        .hit_i       (hit),
        .arm_i       (arm),
        .nov_i       (nov_i),
        .rd_cap_i    (rd_cap_i),
        .rd_hold_i   (rd_hold_i),
        .cap_o       (cap_o),
        .hold_o      (hold_o),
        .cap_full_o  (cap_full_o),
        .hold_full_o (hold_full_o),
        .set_o       (set_evt)
    );

    icap_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_evt),
        .wr_i    (flag_wr_i),
        .wdata_i (flag_wdata_i),
        .flag_o  (flag_o)
    );

    // R5: with the channel off the timestamps do not move
    a_r5_off_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ICAP_OFF) |=> ($stable(cap_o) && $stable(hold_o)));

    // R3: the flag only rises together with a full pair or a released edge
    a_r3_flag_with_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_evt) |=> !flag_o);

endmodule

// File: tb/icap_buf_chan_test.sv
module icap_buf_chan_test;

    localparam int W   = 16;
    localparam int SS  = 3;
    localparam int LAT = SS + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] count_i = '0;
    logic         pin_i = 1'b0;
    logic         mode_wr_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic         nov_i = 1'b0;
    logic         rd_cap_i = 1'b0;
    logic         rd_hold_i = 1'b0;
    logic         flag_wr_i = 1'b0;
    logic         flag_wdata_i = 1'b0;
    logic [W-1:0] cap_o, hold_o;
    logic         cap_full_o, hold_full_o, flag_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    icap_buf_chan #(.CNT_W(W), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .pin_i(pin_i),
        .mode_wr_i(mode_wr_i), .mode_i(mode_i), .nov_i(nov_i),
        .rd_cap_i(rd_cap_i), .rd_hold_i(rd_hold_i),
        .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .cap_o(cap_o), .hold_o(hold_o), .cap_full_o(cap_full_o),
        .hold_full_o(hold_full_o), .flag_o(flag_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i = m; mode_wr_i = 1'b1;
        step();
        mode_wr_i = 1'b0;
    endtask

    task automatic toggle(input logic lvl, input logic [W-1:0] c);
        count_i = c; pin_i = lvl;
        repeat (LAT) step();
    endtask

    task automatic clear_flag();
        flag_wr_i = 1'b1; flag_wdata_i = 1'b1;
        step();
        flag_wr_i = 1'b0; flag_wdata_i = 1'b0;
    endtask

    task automatic read_cap();
        rd_cap_i = 1'b1; step(); rd_cap_i = 1'b0;
    endtask

    task automatic read_hold();
        rd_hold_i = 1'b1; step(); rd_hold_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "reset flag", flag_o, 0);
        chk("R1", "reset cap_full", cap_full_o, 0);
        chk("R1", "reset hold_full", hold_full_o, 0);
        chk("R1", "reset cap", cap_o, 0);
    endtask

    task automatic t_rise_basic();
        nov_i = 1'b0;
        set_mode(2'b01);
        toggle(1'b1, 16'h1111);
        chk("R2", "first cap", cap_o, 16'h1111);
        chk("R2", "first cap_full", cap_full_o, 1);
        chk("R2", "first flag", flag_o, 0);
        toggle(1'b0, 16'h1AAA);
        chk("R4", "falling ignored", cap_o, 16'h1111);
        toggle(1'b1, 16'h2222);
        chk("R3", "shift hold", hold_o, 16'h1111);
        chk("R3", "shift cap", cap_o, 16'h2222);
        chk("R3", "flag set", flag_o, 1);
        chk("R3", "both full", {cap_full_o, hold_full_o}, 2'b11);
        toggle(1'b0, 16'h2AAA);
        toggle(1'b1, 16'h3333);
        chk("R10", "unread hold", hold_o, 16'h2222);
        chk("R10", "unread cap", cap_o, 16'h3333);
        clear_flag();
        chk("R9", "clear", flag_o, 0);
    endtask

    task automatic t_polarity();
        set_mode(2'b10);
        chk("R1", "rearm empties", {cap_full_o, hold_full_o}, 2'b00);
        toggle(1'b0, 16'h4444);
        chk("R4", "fall first cap", cap_o, 16'h4444);
        chk("R2", "fall first flag", flag_o, 0);
        toggle(1'b1, 16'h5555);
        chk("R4", "rise ignored", cap_o, 16'h4444);
        toggle(1'b0, 16'h6666);
        chk("R4", "fall shift", {cap_o, hold_o}, {16'h6666, 16'h4444});
        chk("R3", "fall flag", flag_o, 1);
        clear_flag();
        set_mode(2'b11);
        toggle(1'b1, 16'h7777);
        chk("R4", "any first", cap_o, 16'h7777);
        toggle(1'b0, 16'h8888);
        chk("R4", "any shift", {cap_o, hold_o}, {16'h8888, 16'h7777});
        clear_flag();
    endtask

    task automatic t_disable();
        set_mode(2'b00);
        toggle(1'b1, 16'h9999);
        toggle(1'b0, 16'h9998);
        chk("R5", "off cap", cap_o, 16'h8888);
        chk("R5", "off hold", hold_o, 16'h7777);
        chk("R5", "off flag", flag_o, 0);
    endtask

    task automatic t_nov_read_then_edge();
        nov_i = 1'b1;
        set_mode(2'b01);
        toggle(1'b1, 16'hA000);
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hA001);
        chk("R3", "nov shift flag", flag_o, 1);
        clear_flag();
        read_cap();
        chk("R7", "cap emptied", cap_full_o, 0);
        chk("R7", "hold kept", hold_full_o, 1);
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hA002);
        chk("R6", "blocked cap", cap_o, 16'hA001);
        chk("R6", "blocked hold", hold_o, 16'hA000);
        chk("R6", "blocked flag", flag_o, 0);
        read_hold();
        chk("R7", "hold emptied", hold_full_o, 0);
        chk("R8", "flag not yet", flag_o, 0);
        step();
        chk("R8", "flag released", flag_o, 1);
        clear_flag();
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hA003);
        chk("R11", "empty fill cap", cap_o, 16'hA003);
        chk("R11", "empty fill full", {cap_full_o, hold_full_o}, 2'b10);
        chk("R11", "empty fill flag", flag_o, 0);
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hA004);
        chk("R3", "refill shift", {cap_o, hold_o}, {16'hA004, 16'hA003});
    endtask

    task automatic t_nov_clear_with_read();
        read_cap();
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hB000);
        chk("R6", "blocked again", cap_o, 16'hA004);
        rd_hold_i = 1'b1; flag_wr_i = 1'b1; flag_wdata_i = 1'b1;
        step();
        rd_hold_i = 1'b0; flag_wr_i = 1'b0; flag_wdata_i = 1'b0;
        chk("R8", "cleared with read", flag_o, 0);
        step();
        chk("R8", "flag not lost", flag_o, 1);
        chk("R8", "regs untouched", {cap_o, hold_o}, {16'hA004, 16'hA003});
    endtask

    task automatic t_flag_write();
        flag_wr_i = 1'b1; flag_wdata_i = 1'b0;
        step();
        flag_wr_i = 1'b0;
        chk("R9", "zero write no effect", flag_o, 1);
        clear_flag();
        nov_i = 1'b0;
        toggle(1'b0, 16'h0000);
        count_i = 16'hC000; pin_i = 1'b1;
        repeat (LAT - 1) step();
        flag_wr_i = 1'b1; flag_wdata_i = 1'b1;
        step();
        flag_wr_i = 1'b0; flag_wdata_i = 1'b0;
        chk("R9", "set wins", flag_o, 1);
        chk("R10", "shift on clear", {cap_o, hold_o}, {16'hC000, 16'hA004});
    endtask

    task automatic t_rearm();
        set_mode(2'b01);
        chk("R1", "rearm while full", {cap_full_o, hold_full_o}, 2'b00);
        clear_flag();
        toggle(1'b0, 16'h0000);
        toggle(1'b1, 16'hD000);
        chk("R1", "restart silent", flag_o, 0);
        chk("R1", "restart cap", cap_o, 16'hD000);
        chk("R1", "restart hold empty", hold_full_o, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_rise_basic();
        t_polarity();
        t_disable();
        t_nov_read_then_edge();
        t_nov_clear_with_read();
        t_flag_write();
        t_rearm();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule